// File: doc/BRIEF.md
# Systolic Horner Polynomial Pipeline

This block evaluates a fixed-degree polynomial p(x) = c_D·x^D + … + c_1·x + c_0 for a stream of integer samples. It uses a linear chain of 2·D registered stages. The stages work in pairs: the first stage of each pair multiplies the running sum by the sample, and the second adds one stored coefficient. Each sample travels through the chain next to its own partial sum and a valid flag. Up to 2·D different samples can therefore be in flight at once, and a new sample can enter on every clock while the consumer keeps taking results.

Before a run, software loads the D+1 coefficients through a small indexed write port. Samples enter on a valid/ready handshake on the left. Results leave on a valid/ready handshake on the right. If the consumer refuses a waiting result, every stage freezes. All arithmetic is signed two's-complement at the data width, and it wraps on overflow.

Each stage slot is either empty or occupied. On an advance cycle, every occupied or empty slot moves one step to the right. On a stall cycle, every slot holds.

Top module: `horner_pipe`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and all coefficients are zero, so a sample accepted before any coefficient write yields 0.
- R2: A write with cfg_we=1 and cfg_idx=j (0 ≤ j ≤ DEG) sets coefficient c_j to cfg_data. Each accepted x then yields y = ((c_DEG·x + c_(DEG-1))·x + … + c_1)·x + c_0.
- R3: With out_ready held at 1, a sample accepted in clock cycle t produces out_valid=1 with its result in cycle t+2·DEG. out_valid is 0 in the cycles between.
- R4: While out_ready stays 1, in_ready stays 1, so one sample is accepted on every clock. Once the pipeline is full, a result leaves on every clock.
- R5: While out_valid=1 and out_ready=0, in_ready is 0, and out_valid and out_y keep their values into the next cycle.
- R6: Results leave in the order their samples were accepted. No result is lost and none is repeated.
- R7: Every multiply and add keeps only the low DATA_W bits of the exact result, treated as two's-complement.
- R8: A coefficient write with cfg_idx greater than DEG has no effect on any later result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A sample is offered on in_x |
| in_ready | output | 1 | The pipeline takes the offered sample on this edge |
| in_x | input | DATA_W | Sample value, signed |
| out_valid | output | 1 | out_y holds a finished result |
| out_ready | input | 1 | The consumer takes out_y on this edge |
| out_y | output | DATA_W | Polynomial value, signed |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_idx | input | clog2(DEG+1) | Coefficient index j |
| cfg_data | input | DATA_W | Coefficient value, signed |

## Verification
A corrupted partial sum or sample register in any stage shows up as a wrong out_y exactly 2·DEG advance cycles after that sample was accepted. The error therefore appears at the port within one pipeline traversal. A broken valid chain or stall enable appears as a missing, repeated or early result. The bench catches this in the first cycle the scoreboard order diverges, or in the first stall cycle where out_y moves. A wrong coefficient index map appears on the first sample evaluated after the write.

// File: rtl/horner_pkg.sv
package horner_pkg;
    typedef enum logic {
        STG_MUL = 1'b0,
        STG_ADD = 1'b1
    } stage_kind_e;
endpackage

// File: rtl/hp_coef_bank.sv
module hp_coef_bank #(
    parameter int DEG    = 4,
    parameter int DATA_W = 16,
    parameter int IW     = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [IW-1:0]             idx,
    input  logic [DATA_W-1:0]         data,
    output logic [DEG:0][DATA_W-1:0]  coef_o
);
    logic in_range;
    assign in_range = (int'(idx) <= DEG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coef_o <= '0;
        end else if (we && in_range) begin
            coef_o[idx] <= data;
        end
    end

    // R8: out-of-range index leaves every coefficient untouched
    a_r8_ignore_high_idx: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !in_range) |=> $stable(coef_o));

    // R2: in-range write lands in the addressed slot
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we && in_range) |=> (coef_o[$past(idx)] == $past(data)));
endmodule

// File: rtl/hp_stage.sv
module hp_stage
    import horner_pkg::*;
#(
    parameter int          DATA_W = 16,
    parameter stage_kind_e KIND   = STG_MUL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_x,
    input  logic [DATA_W-1:0] in_acc,
    input  logic [DATA_W-1:0] opnd,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_x,
    output logic [DATA_W-1:0] out_acc
);
    logic [DATA_W-1:0] acc_nxt;

    generate
        if (KIND == STG_MUL) begin : g_mul
            // low DATA_W bits of the product equal the two's-complement wrap
            assign acc_nxt = in_acc * opnd;
        end else begin : g_add
            assign acc_nxt = in_acc + opnd;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_x   <= '0;
            out_acc <= '0;
        end else if (adv) begin
            out_vld <= in_vld;
            out_x   <= in_x;
            out_acc <= acc_nxt;
        end
    end

    // R6: a slot's occupancy moves exactly one stage per advance
    a_r6_slot_moves: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (out_vld == $past(in_vld)));

    // R5: nothing moves while stalled
    a_r5_slot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> ($stable(out_vld) && $stable(out_acc) && $stable(out_x)));
endmodule

// File: rtl/horner_pipe.sv
module horner_pipe
    import horner_pkg::*;
#(
    parameter int DEG    = 4,
    parameter int DATA_W = 16,
    localparam int IW    = (DEG > 0) ? $clog2(DEG + 1) : 1,
    localparam int NS    = 2 * DEG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_x,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_y,
    input  logic              cfg_we,
    input  logic [IW-1:0]     cfg_idx,
    input  logic [DATA_W-1:0] cfg_data
);
    logic [DEG:0][DATA_W-1:0] coef;
    logic [NS:0]              vld;
    logic [NS:0][DATA_W-1:0]  xs;
    logic [NS:0][DATA_W-1:0]  acc;
    logic                     adv;

    hp_coef_bank #(.DEG(DEG), .DATA_W(DATA_W), .IW(IW)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .idx    (cfg_idx),
        .data   (cfg_data),
        .coef_o (coef)
    );

    // leading coefficient rides in beside the sample
    assign vld[0] = in_valid;
    assign xs[0]  = in_x;
    assign acc[0] = coef[DEG];

    // single stall enable for the whole chain
    assign adv      = !vld[NS] || out_ready;
    assign in_ready = adv;

    generate
        for (genvar s = 0; s < NS; s++) begin : g_stage
            localparam stage_kind_e K  = (s % 2 == 0) ? STG_MUL : STG_ADD;
            localparam int          CI = DEG - 1 - (s / 2);
            logic [DATA_W-1:0] opnd;
            if (K == STG_MUL) begin : g_op_x
                assign opnd = xs[s];
            end else begin : g_op_c
                assign opnd = coef[CI];
            end
            hp_stage #(.DATA_W(DATA_W), .KIND(K)) u_stg (
                .clk     (clk),
                .rst_n   (rst_n),
                .adv     (adv),
                .in_vld  (vld[s]),
                .in_x    (xs[s]),
                .in_acc  (acc[s]),
                .opnd    (opnd),
                .out_vld (vld[s+1]),
                .out_x   (xs[s+1]),
                .out_acc (acc[s+1])
            );
        end
    endgenerate

    assign out_valid = vld[NS];
    assign out_y     = acc[NS];

    // R5: a refused result blocks intake
    a_r5_no_intake: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R5: refused result and its sample stay put
    a_r5_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_y) && $stable(xs[NS])));

    // R4: a ready consumer never throttles intake
    a_r4_open_intake: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |-> in_ready);

    // R1: reset leaves the output empty
    a_r1_reset_empty: assert property (@(posedge clk)
        !rst_n |=> (!out_valid || rst_n));
endmodule

// File: tb/tb_horner_pipe.sv
`timescale 1ns/1ps
module tb_horner_pipe;
    localparam int DEG = 4;
    localparam int W   = 16;
    localparam int NS  = 2 * DEG;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid, in_ready, out_valid, out_ready, cfg_we;
    logic [W-1:0] in_x, out_y, cfg_data;
    logic [2:0]   cfg_idx;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [W-1:0] model [0:DEG];
    logic [W-1:0] exp_q [$];
    bit           was_stall = 1'b0;
    logic [W-1:0] held_y;

    always #2 clk = ~clk;

    horner_pipe #(.DEG(DEG), .DATA_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_x(in_x), .out_valid(out_valid), .out_ready(out_ready), .out_y(out_y),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data)
    );

    function automatic longint sx(logic [W-1:0] v);
        return longint'($signed(v));
    endfunction

    // R2 R7: exact Horner in 64 bits, then keep the low W bits
    function automatic logic [W-1:0] ref_y(logic [W-1:0] x);
        longint a;
        a = sx(model[DEG]);
        for (int j = DEG - 1; j >= 0; j--) a = a * sx(x) + sx(model[j]);
        return a[W-1:0];
    endfunction

    task automatic chk(string req, longint got, longint expv);
        checks++;
        if (got != expv) begin
            errs++;
            $display("FAIL %s: got %0d expected %0d", req, got, expv);
        end
    endtask

    task automatic monitor();
        if (was_stall) begin
            chk("R5 valid held", out_valid, 1);
            chk("R5 data held", out_y, held_y);
        end
        if (out_valid && !out_ready) chk("R5 intake blocked", in_ready, 0);
        if (in_valid && in_ready) exp_q.push_back(ref_y(in_x));
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) chk("R6 extra result", 1, 0);
            else chk("R2 R6 R7 result", sx(out_y), sx(exp_q.pop_front()));
        end
        was_stall = out_valid && !out_ready;
        held_y = out_y;
    endtask

    task automatic cycle(bit iv, logic [W-1:0] x, bit ordy);
        @(negedge clk);
        in_valid = iv; in_x = x; out_ready = ordy; cfg_we = 1'b0;
        #1 monitor();
    endtask

    task automatic write_coef(int idx, int val);
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b1;
        cfg_we = 1'b1; cfg_idx = idx[2:0]; cfg_data = val[W-1:0];
        #1 monitor();
        if (idx <= DEG) model[idx] = val[W-1:0];
    endtask

    task automatic drain();
        for (int i = 0; i < NS + 2; i++) cycle(1'b0, '0, 1'b1);
        chk("R6 nothing lost", exp_q.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk("R6 watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; in_valid = 1'b0; in_x = '0; out_ready = 1'b1;
        cfg_we = 1'b0; cfg_idx = '0; cfg_data = '0;
        for (int j = 0; j <= DEG; j++) model[j] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 out_valid after reset", out_valid, 0);
        chk("R1 in_ready after reset", in_ready, 1);

        // R1: zero coefficients give zero
        cycle(1'b1, 16'd1234, 1'b1);
        drain();

        // R2: directed coefficients and samples
        write_coef(0, 3); write_coef(1, -2); write_coef(2, 5);
        write_coef(3, 1); write_coef(4, 2);
        cycle(1'b1, 16'd0, 1'b1);
        cycle(1'b1, 16'd1, 1'b1);
        cycle(1'b1, 16'hFFFF, 1'b1);
        cycle(1'b1, 16'd2, 1'b1);
        drain();

        // R3: latency of exactly 2*DEG cycles
        cycle(1'b1, 16'd7, 1'b1);
        for (int i = 1; i <= NS; i++) begin
            cycle(1'b0, '0, 1'b1);
            chk("R3 latency", out_valid, (i == NS) ? 1 : 0);
        end
        drain();

        // R4: full rate
        for (int i = 0; i < 40; i++) begin
            cycle(1'b1, W'($urandom), 1'b1);
            chk("R4 in_ready", in_ready, 1);
            chk("R4 out_valid rate", out_valid, (i >= NS) ? 1 : 0);
        end
        drain();

        // R7: wrap with extreme values
        write_coef(4, 32767); write_coef(3, -32768); write_coef(2, 32767);
        write_coef(1, -1); write_coef(0, 12345);
        cycle(1'b1, 16'h7FFF, 1'b1);
        cycle(1'b1, 16'h8000, 1'b1);
        cycle(1'b1, 16'h7FFE, 1'b1);
        drain();

        // R8: out-of-range writes ignored
        write_coef(4, 0); write_coef(3, 0); write_coef(2, 0); write_coef(1, 0);
        write_coef(0, 7);
        write_coef(5, 999); write_coef(7, -5);
        cycle(1'b1, 16'd3, 1'b1);
        drain();

        // random traffic with stalls, R5 R6
        for (int r = 0; r < 4; r++) begin
            for (int j = 0; j <= DEG; j++) write_coef(j, int'($urandom) % 65536);
            for (int i = 0; i < 1500; i++)
                cycle(($urandom % 10) < 7, W'($urandom), ($urandom % 10) < 6);
            drain();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule